// File: doc/BRIEF.md
# Critical-Conduction PFC Gate Sequencer

This block times the gate of the switch in a boost power-factor-correction stage that runs in critical conduction, also called boundary mode. It has no free-running clock for switching. A gate pulse begins when the inductor has fully demagnetised. The bench-side comparators report this as an auxiliary-winding voltage that first goes above an upper threshold and then drops below a lower threshold. The pulse length comes from a digital on-time command word. That word stands in for the compensation level, which an outer voltage loop produces.

The sequencer also covers three abnormal cases:

- **Missing zero crossing.** If the zero-crossing sequence does not arrive, a watchdog forces a pulse of the commanded length. It keeps doing so once per watchdog period until a valid sequence comes back.
- **Over-current.** An over-current flag ends the current pulse early. A blanking window at the start of each pulse masks leading-edge spikes.
- **Over-voltage or disable.** A bus over-voltage flag, or a low enable, holds the gate low and parks the machine in a halted state.

The zero-crossing and protection flags pass through two-flop synchronisers. The machine has four states:

- `ST_HALT`: disabled, gate low.
- `ST_ON`: gate high.
- `ST_MINOFF`: enforced low time after a pulse.
- `ST_WAIT`: gate low, waiting for a zero crossing or the watchdog.

The machine takes these named transitions:

- *enable*: `ST_HALT` to `ST_WAIT`.
- *zx_start*: `ST_WAIT` to `ST_ON`, when the machine is armed and the lower flag is seen.
- *wd_start*: `ST_WAIT` to `ST_ON`, when the watchdog has expired.
- *ton_end*: `ST_ON` to `ST_MINOFF`, when the on-time is complete.
- *oc_end*: `ST_ON` to `ST_MINOFF`, on over-current after blanking.
- *minoff_done*: `ST_MINOFF` to `ST_WAIT`.
- *halt*: any state to `ST_HALT`, on over-voltage or enable low.

Top module: `crm_pfc_gate_seq`

## Requirements
- R1: While reset is applied, and after it is released with enable low, `gate_o`, `wd_mode_o` and `oc_trip_o` are all 0.
- R2: A pulse lasts exactly max(C,1) clock cycles. C is the value of `ton_cmd` latched in the cycle the pulse starts. Later changes to `ton_cmd` do not alter a pulse that is already running.
- R3: During gate-low time (`ST_MINOFF` or `ST_WAIT`), a synchronised high on `zx_hi_i` arms the machine. Once armed and in `ST_WAIT`, a high on `zx_lo_i` starts a pulse. `gate_o` goes high after the third rising clock edge that follows the change on the `zx_lo_i` pin.
- R4: A high on `zx_lo_i` that is not preceded by a `zx_hi_i` high in the same gate-low interval starts no pulse.
- R5: If no zero-crossing start occurs, the watchdog starts a pulse exactly WD_CYCLES cycles after the previous turn-on, or after leaving `ST_HALT`. Forced pulses repeat with that period. `wd_mode_o` is 1 after a forced start and 0 after a zero-crossing start.
- R6: During a pulse, once more than BLANK_CYC on-cycles have elapsed, a synchronised over-current flag ends the pulse. If the flag is held high throughout, the pulse is BLANK_CYC+1 cycles long. `oc_trip_o` is then 1 until the next turn-on.
- R7: Over-current during the first BLANK_CYC cycles of a pulse is ignored. With the flag held high and C <= BLANK_CYC, the pulse keeps its full length C and `oc_trip_o` stays 0.
- R8: After an over-current turn-off, the gate stays low until a valid zero-crossing sequence or the watchdog starts the next pulse.
- R9: Between two pulses with no halt in between, the gate is low for at least MIN_OFF+1 cycles.
- R10: When `ovp_i` goes high, `gate_o` is low after the third rising edge and stays low while `ovp_i` is high. The arming state is cleared. After release, a `zx_lo_i` high without a fresh `zx_hi_i` starts no pulse.
- R11: With `en` low, `gate_o` is low after the next rising edge and the machine enters `ST_HALT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Switching enable, already synchronous |
| zx_hi_i | input | 1 | Auxiliary winding above upper threshold (asynchronous) |
| zx_lo_i | input | 1 | Auxiliary winding below lower threshold (asynchronous) |
| oc_i | input | 1 | Switch current above limit (asynchronous) |
| ovp_i | input | 1 | Bus over-voltage (asynchronous) |
| ton_cmd | input | ON_W | On-time command in clock cycles |
| gate_o | output | 1 | Gate drive |
| wd_mode_o | output | 1 | Last pulse was started by the watchdog |
| oc_trip_o | output | 1 | Last pulse was ended by over-current |

## Verification
The main function is tried with four input patterns:

- **No zero crossing at all.** This isolates the watchdog period and the pulse width. Ringing on the lower flag is added, which shows that an unarmed falling indication is rejected.
- **A clean upper-then-lower sequence.** This pins the exact start latency through the synchronisers. Changing the command mid-pulse separates a latched on-time from a live one.
- **An immediate re-arm at turn-off.** This makes the minimum off-time, not the zero crossing, the limit on the gap.
- **Over-current held high with long and short commands.** This tells blanking apart from termination.

Over-voltage and enable-low cases during a pulse check the halt latency and that arming is lost.

// File: rtl/crm_pfc_pkg.sv
package crm_pfc_pkg;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_ON     = 2'd1,
        ST_MINOFF = 2'd2,
        ST_WAIT   = 2'd3
    } gate_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // timer must hold the largest on-time command plus headroom for the blanking
    // and min-off compares
    function automatic int unsigned tmr_width(input int unsigned on_w,
                                              input int unsigned blank_cyc,
                                              input int unsigned min_off);
        return max_u(on_w, max_u($clog2(blank_cyc + 2), $clog2(min_off + 2))) + 1;
    endfunction

endpackage

// File: rtl/crm_sync_bank.sv
module crm_sync_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1;
        logic s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end

endmodule

// File: rtl/crm_wdog.sv
module crm_wdog #(
    parameter int WD_CYCLES = 43750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);

    localparam int            CW  = $clog2(WD_CYCLES);
    localparam logic [CW-1:0] LIM = CW'(WD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM);

endmodule

// File: rtl/crm_gate_fsm.sv
module crm_gate_fsm
    import crm_pfc_pkg::*;
#(
    parameter int ON_W      = 10,
    parameter int BLANK_CYC = 8,
    parameter int MIN_OFF   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 zx_hi_s,
    input  logic                 zx_lo_s,
    input  logic                 oc_s,
    input  logic                 ovp_s,
    input  logic [ON_W-1:0]      ton_cmd,
    input  logic                 wd_exp,
    output logic                 gate_o,
    output logic                 wd_mode_o,
    output logic                 oc_trip_o,
    output logic                 wd_restart_o,
    output gate_state_e          state_o,
    output logic                 armed_o,
    output logic [tmr_width(ON_W, BLANK_CYC, MIN_OFF)-1:0] on_tmr_o,
    output logic [ON_W-1:0]      ton_lat_o
);

    localparam int              TMR_W     = tmr_width(ON_W, BLANK_CYC, MIN_OFF);
    localparam logic [TMR_W-1:0] BLANK_T  = TMR_W'(BLANK_CYC);
    localparam logic [TMR_W-1:0] MINOFF_T = TMR_W'(MIN_OFF);
    localparam logic [ON_W-1:0]  ONE_CMD  = ON_W'(1);

    gate_state_e      state;
    gate_state_e      nxt;
    logic [TMR_W-1:0] tmr;
    logic [ON_W-1:0]  ton_lat;
    logic             armed;
    logic             wd_mode;
    logic             oc_trip;
    logic             go_on;
    logic             go_wd;
    logic             oc_end;

    // next-state and transition decode
    always_comb begin
        nxt    = state;
        go_on  = 1'b0;
        go_wd  = 1'b0;
        oc_end = 1'b0;
        if (!en || ovp_s) begin
            nxt = ST_HALT;                                   // halt
        end else begin
            unique case (state)
                ST_HALT: begin
                    nxt = ST_WAIT;                           // enable
                end
                ST_ON: begin
                    if (oc_s && (tmr > BLANK_T)) begin
                        nxt    = ST_MINOFF;                  // oc_end
                        oc_end = 1'b1;
                    end else if (tmr >= {{(TMR_W-ON_W){1'b0}}, ton_lat}) begin
                        nxt = ST_MINOFF;                     // ton_end
                    end
                end
                ST_MINOFF: begin
                    if (tmr >= MINOFF_T) begin
                        nxt = ST_WAIT;                       // minoff_done
                    end
                end
                ST_WAIT: begin
                    if (armed && zx_lo_s) begin
                        nxt   = ST_ON;                       // zx_start
                        go_on = 1'b1;
                    end else if (wd_exp) begin
                        nxt   = ST_ON;                       // wd_start
                        go_on = 1'b1;
                        go_wd = 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= nxt;
        end
    end

    // per-state timer, on-time latch and zero-crossing arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr     <= '0;
            ton_lat <= ONE_CMD;
            armed   <= 1'b0;
        end else begin
            if (nxt != state) begin
                tmr <= TMR_W'(1);
            end else if (tmr != '1) begin
                tmr <= tmr + 1'b1;
            end
            if (go_on) begin
                ton_lat <= (ton_cmd == '0) ? ONE_CMD : ton_cmd;
            end
            if (go_on || state == ST_HALT) begin
                armed <= 1'b0;
            end else if ((state == ST_MINOFF || state == ST_WAIT) && zx_hi_s) begin
                armed <= 1'b1;
            end
        end
    end

    // status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_mode <= 1'b0;
            oc_trip <= 1'b0;
        end else if (state == ST_HALT) begin
            wd_mode <= 1'b0;
            oc_trip <= 1'b0;
        end else if (go_on) begin
            wd_mode <= go_wd;
            oc_trip <= 1'b0;
        end else if (oc_end) begin
            oc_trip <= 1'b1;
        end
    end

    always_comb begin
        gate_o       = (state == ST_ON);
        wd_mode_o    = wd_mode;
        oc_trip_o    = oc_trip;
        wd_restart_o = (state == ST_HALT) || go_on;
        state_o      = state;
        armed_o      = armed;
        on_tmr_o     = tmr;
        ton_lat_o    = ton_lat;
    end

endmodule

// File: rtl/crm_pfc_gate_seq.sv
module crm_pfc_gate_seq
    import crm_pfc_pkg::*;
#(
    parameter int ON_W      = 10,
    parameter int BLANK_CYC = 8,
    parameter int MIN_OFF   = 4,
    parameter int WD_CYCLES = 43750
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            zx_hi_i,
    input  logic            zx_lo_i,
    input  logic            oc_i,
    input  logic            ovp_i,
    input  logic [ON_W-1:0] ton_cmd,
    output logic            gate_o,
    output logic            wd_mode_o,
    output logic            oc_trip_o
);

    localparam int TMR_W = tmr_width(ON_W, BLANK_CYC, MIN_OFF);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] sync_q;
    logic             zx_hi_s;
    logic             zx_lo_s;
    logic             oc_s;
    logic             ovp_s;
    logic             wd_exp;
    logic             wd_restart;
    gate_state_e      state_w;
    logic             armed_w;
    logic [TMR_W-1:0] on_tmr_w;
    logic [ON_W-1:0]  ton_lat_w;

    crm_sync_bank #(.N(NSYNC)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ovp_i, oc_i, zx_lo_i, zx_hi_i}),
        .q     (sync_q)
    );

    assign zx_hi_s = sync_q[0];
    assign zx_lo_s = sync_q[1];
    assign oc_s    = sync_q[2];
    assign ovp_s   = sync_q[3];

    crm_wdog #(.WD_CYCLES(WD_CYCLES)) i_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wd_restart),
        .expired (wd_exp)
    );

    crm_gate_fsm #(
        .ON_W      (ON_W),
        .BLANK_CYC (BLANK_CYC),
        .MIN_OFF   (MIN_OFF)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .zx_hi_s      (zx_hi_s),
        .zx_lo_s      (zx_lo_s),
        .oc_s         (oc_s),
        .ovp_s        (ovp_s),
        .ton_cmd      (ton_cmd),
        .wd_exp       (wd_exp),
        .gate_o       (gate_o),
        .wd_mode_o    (wd_mode_o),
        .oc_trip_o    (oc_trip_o),
        .wd_restart_o (wd_restart),
        .state_o      (state_w),
        .armed_o      (armed_w),
        .on_tmr_o     (on_tmr_w),
        .ton_lat_o    (ton_lat_w)
    );

endmodule

// File: rtl/crm_pfc_gate_seq_chk.sv
module crm_pfc_gate_seq_chk
    import crm_pfc_pkg::*;
#(
    parameter int ON_W      = 10,
    parameter int BLANK_CYC = 8,
    parameter int MIN_OFF   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            gate_o,
    input logic            ovp_s,
    input logic            oc_s,
    input logic            wd_exp,
    input logic            armed,
    input gate_state_e     st,
    input logic [tmr_width(ON_W, BLANK_CYC, MIN_OFF)-1:0] on_tmr,
    input logic [ON_W-1:0] ton_lat
);

    localparam int TMR_W = tmr_width(ON_W, BLANK_CYC, MIN_OFF);

    logic [7:0] low_cnt;
    logic       had_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            had_pulse <= 1'b0;
        end else begin
            if (gate_o) begin
                low_cnt <= '0;
            end else if (low_cnt != 8'hff) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (st == ST_HALT) begin
                had_pulse <= 1'b0;
            end else if (gate_o) begin
                had_pulse <= 1'b1;
            end
        end
    end

    a_r2_on_time_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> ({{(TMR_W-ON_W){1'b0}}, ton_lat} >= on_tmr));

    a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> ($past(armed) || $past(wd_exp)));

    a_r5_wd_forces_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && wd_exp && en && !ovp_s) |=> gate_o);

    a_r6_oc_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && oc_s && on_tmr > TMR_W'(BLANK_CYC)) |=> !gate_o);

    a_r9_min_off_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && !$past(gate_o) && had_pulse) |-> (low_cnt >= 8'(MIN_OFF + 1)));

    a_r10_ovp_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_s |=> !gate_o);

    a_r11_disable_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!gate_o && st == ST_HALT));

endmodule

bind crm_pfc_gate_seq crm_pfc_gate_seq_chk #(
    .ON_W      (ON_W),
    .BLANK_CYC (BLANK_CYC),
    .MIN_OFF   (MIN_OFF)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .gate_o  (gate_o),
    .ovp_s   (ovp_s),
    .oc_s    (oc_s),
    .wd_exp  (wd_exp),
    .armed   (armed_w),
    .st      (state_w),
    .on_tmr  (on_tmr_w),
    .ton_lat (ton_lat_w)
);

// File: tb/test_crm_pfc_gate_seq.sv
module test_crm_pfc_gate_seq;

    localparam int ON_W      = 10;
    localparam int BLANK_CYC = 8;
    localparam int MIN_OFF   = 4;
    localparam int WD_CYCLES = 400;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic            zx_hi_i = 1'b0;
    logic            zx_lo_i = 1'b0;
    logic            oc_i = 1'b0;
    logic            ovp_i = 1'b0;
    logic [ON_W-1:0] ton_cmd = '0;
    logic            gate_o;
    logic            wd_mode_o;
    logic            oc_trip_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    crm_pfc_gate_seq #(
        .ON_W      (ON_W),
        .BLANK_CYC (BLANK_CYC),
        .MIN_OFF   (MIN_OFF),
        .WD_CYCLES (WD_CYCLES)
    ) i_crm_pfc_gate_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .zx_hi_i   (zx_hi_i),
        .zx_lo_i   (zx_lo_i),
        .oc_i      (oc_i),
        .ovp_i     (ovp_i),
        .ton_cmd   (ton_cmd),
        .gate_o    (gate_o),
        .wd_mode_o (wd_mode_o),
        .oc_trip_o (oc_trip_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // arm with the upper flag, then raise the lower flag; returns at the
    // negedge where zx_lo_i was raised
    task automatic do_zx();
        @(negedge clk);
        zx_hi_i = 1'b1;
        repeat (4) @(negedge clk);
        zx_hi_i = 1'b0;
        zx_lo_i = 1'b1;
    endtask

    task automatic wait_rise();
        for (int g = 0; g < 2000 && gate_o !== 1'b1; g++) @(negedge clk);
    endtask

    // counts high negedges; returns at first low negedge
    task automatic meas_high(output int w, input int new_cmd);
        wait_rise();
        w = 0;
        while (gate_o === 1'b1 && w < 2000) begin
            w++;
            if (w == 2 && new_cmd >= 0) ton_cmd = ON_W'(new_cmd);
            @(negedge clk);
        end
    endtask

    task automatic meas_low(output int l);
        l = 0;
        while (gate_o === 1'b0 && l < 2000) begin
            l++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(gate_o === 1'b0 && wd_mode_o === 1'b0 && oc_trip_o === 1'b0,
              "R1 during reset", int'(gate_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(gate_o === 1'b0 && wd_mode_o === 1'b0 && oc_trip_o === 1'b0,
              "R1 after reset, enable low", int'(gate_o), 0);
    endtask

    task automatic t_watchdog();
        int bad_hi = 0;
        int w;
        int l;
        ton_cmd = ON_W'(20);
        @(negedge clk);
        en = 1'b1;
        for (int i = 1; i <= WD_CYCLES; i++) begin
            @(negedge clk);
            if (i == 100 || i == 200) zx_lo_i = 1'b1;   // ringing, never armed
            if (i == 104 || i == 203) zx_lo_i = 1'b0;
            if (gate_o !== 1'b0) bad_hi++;
        end
        check(bad_hi == 0, "R4 unarmed lower flag ignored before watchdog", bad_hi, 0);
        @(negedge clk);
        check(gate_o === 1'b1, "R5 forced start at WD_CYCLES", int'(gate_o), 1);
        check(wd_mode_o === 1'b1, "R5 wd_mode_o after forced start", int'(wd_mode_o), 1);
        meas_high(w, -1);
        check(w == 20, "R2 forced pulse width", w, 20);
        meas_low(l);
        check(l == WD_CYCLES - 20, "R5 forced restart period", l, WD_CYCLES - 20);
        meas_high(w, -1);
        check(w == 20, "R2 second forced pulse width", w, 20);
    endtask

    task automatic t_zx();
        int w;
        repeat (10) @(negedge clk);
        do_zx();
        @(negedge clk);
        @(negedge clk);
        check(gate_o === 1'b0, "R3 no start before third edge", int'(gate_o), 0);
        @(negedge clk);
        check(gate_o === 1'b1, "R3 start on third edge", int'(gate_o), 1);
        check(wd_mode_o === 1'b0, "R5 wd_mode_o cleared by zx start", int'(wd_mode_o), 0);
        meas_high(w, 7);
        check(w == 20, "R2 width latched despite mid-pulse command change", w, 20);
        zx_lo_i = 1'b0;
    endtask

    task automatic t_minoff();
        int w;
        int l;
        do_zx();
        wait_rise();
        zx_lo_i = 1'b0;
        zx_hi_i = 1'b1;
        meas_high(w, -1);
        check(w == 7, "R2 width of command 7", w, 7);
        zx_hi_i = 1'b0;
        zx_lo_i = 1'b1;
        meas_low(l);
        check(l == MIN_OFF + 1, "R9 gap limited by minimum off-time", l, MIN_OFF + 1);
        meas_high(w, -1);
        zx_lo_i = 1'b0;
        check(w == 7, "R2 width after minimum gap", w, 7);
    endtask

    task automatic t_oc();
        int w;
        int bad_hi = 0;
        ton_cmd = ON_W'(50);
        oc_i = 1'b1;
        repeat (4) @(negedge clk);
        do_zx();
        meas_high(w, -1);
        zx_lo_i = 1'b0;
        check(w == BLANK_CYC + 1, "R6 over-current cuts pulse after blanking", w, BLANK_CYC + 1);
        check(oc_trip_o === 1'b1, "R6 oc_trip_o set", int'(oc_trip_o), 1);
        repeat (10) @(negedge clk);
        oc_i = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (gate_o !== 1'b0) bad_hi++;
        end
        check(bad_hi == 0, "R8 stays low after over-current turn-off", bad_hi, 0);
        do_zx();
        meas_high(w, -1);
        zx_lo_i = 1'b0;
        check(w == 50, "R8 valid zero crossing restarts full pulse", w, 50);
        check(oc_trip_o === 1'b0, "R6 oc_trip_o cleared on next start", int'(oc_trip_o), 0);
    endtask

    task automatic t_blank();
        int w;
        ton_cmd = ON_W'(6);
        oc_i = 1'b1;
        repeat (4) @(negedge clk);
        do_zx();
        meas_high(w, -1);
        zx_lo_i = 1'b0;
        oc_i = 1'b0;
        check(w == 6, "R7 over-current masked inside blanking", w, 6);
        check(oc_trip_o === 1'b0, "R7 oc_trip_o stays clear", int'(oc_trip_o), 0);
        ton_cmd = '0;
        repeat (8) @(negedge clk);
        do_zx();
        meas_high(w, -1);
        zx_lo_i = 1'b0;
        check(w == 1, "R2 zero command gives one cycle", w, 1);
    endtask

    task automatic t_ovp();
        int bad_hi = 0;
        ton_cmd = ON_W'(200);
        repeat (8) @(negedge clk);
        do_zx();
        wait_rise();
        zx_lo_i = 1'b0;
        repeat (5) @(negedge clk);
        ovp_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(gate_o === 1'b1, "R10 gate still high before sync delay", int'(gate_o), 1);
        @(negedge clk);
        check(gate_o === 1'b0, "R10 gate low on third edge", int'(gate_o), 0);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (i == 10) zx_hi_i = 1'b1;
            if (i == 20) zx_hi_i = 1'b0;
            if (gate_o !== 1'b0) bad_hi++;
        end
        ovp_i = 1'b0;
        zx_lo_i = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (gate_o !== 1'b0) bad_hi++;
        end
        zx_lo_i = 1'b0;
        check(bad_hi == 0, "R10 held low and arming cleared", bad_hi, 0);
    endtask

    task automatic t_enable();
        int bad_hi = 0;
        do_zx();
        wait_rise();
        zx_lo_i = 1'b0;
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(gate_o === 1'b0, "R11 gate low one edge after disable", int'(gate_o), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (gate_o !== 1'b0) bad_hi++;
        end
        check(bad_hi == 0, "R11 stays low while disabled", bad_hi, 0);
        check(wd_mode_o === 1'b0 && oc_trip_o === 1'b0, "R1 flags clear while halted",
              int'(wd_mode_o), 0);
        en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_watchdog();
        t_zx();
        t_minoff();
        t_oc();
        t_blank();
        t_ovp();
        t_enable();
        repeat (5) @(negedge clk);
        report();
        $finish;
    end

endmodule